// File: doc/BRIEF.md
# Address-Folded SECDED Codec

This block protects a wide memory word with a single-error-correcting, double-error-detecting code. The code also covers the memory address the word was written to. On the write side a combinational encoder takes the 128-bit data word and its 20-bit address. It produces a 9-bit check field, which the memory stores beside the data. The address itself is not stored. It only feeds into the check bits.

On the read side the decoder receives the stored data, the stored check field and the address being read now. It rebuilds the syndrome and classifies the outcome into one of four cases: clean, corrected single-bit error, uncorrectable error, or address error. A single flipped data bit is repaired before the word is returned. A syndrome that names an address position means the word was read from, or written to, the wrong location. That case is reported on its own flag and the data is left as it was.

For every single-bit event the decoder also gives the index of the bit involved, which feeds error-distribution histograms. The decode results come out through one register stage clocked by the read path.

Top module: `secded_addr_codec`

## Requirements
- R1: Protected bit k (data bits are k = 0..127, address bits are k = 128..147) occupies the k-th position, counting upward from 3, whose value is not a power of two. Check bit j (j = 0..7) is the XOR of the protected bits whose position has bit j set. Check bit 8 makes the XOR of all 148 protected bits and all 9 check bits equal to zero. The check field is produced combinationally on `wr_check`.
- R2: A read whose data, check field and address match a write outputs the data unchanged with all three error flags low.
- R3: A read with exactly one data bit k flipped outputs the corrected data, raises `err_single` only, and reports `err_pos` = k.
- R4: A read with exactly one check bit j flipped (j = 8 is the overall bit) outputs the data unchanged, raises `err_single` only, and reports `err_pos` = 148 + j.
- R5: A read at an address that differs from the written one in exactly bit a raises `err_addr` only, reports `err_pos` = 128 + a, and outputs the data unchanged.
- R6: Any two distinct flips among data, check and address bits raise `err_double` only and output the read data unchanged.
- R7: A syndrome that names a position above 156 while the overall parity is odd raises `err_double` only and outputs the read data unchanged. Flipping check bits 3, 6 and 7 together is one such case.
- R8: Decode outputs take the read inputs present at a rising clock edge and hold them until the next edge. While `rst_n` is low, all decode outputs are zero.
- R9: At most one of the three error flags is high at any time, and `err_pos` is zero unless `err_single` or `err_addr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-path clock |
| rst_n | input | 1 | Synchronous active-low reset of the decode register |
| wr_data | input | 128 | Data word being written |
| wr_addr | input | 20 | Address of the write |
| wr_check | output | 9 | Check field to store with the word (combinational) |
| rd_data | input | 128 | Data word as read from storage |
| rd_check | input | 9 | Check field as read from storage |
| rd_addr | input | 20 | Address of the current read |
| rd_data_fixed | output | 128 | Read data after correction |
| err_single | output | 1 | Correctable single-bit error in data or check bits |
| err_double | output | 1 | Uncorrectable error |
| err_addr | output | 1 | Read address does not match the write address in one bit |
| err_pos | output | 8 | Index of the bit in error for single or address errors |

## Verification
The bench builds the codec with its default widths: 128 data bits, 20 address bits and 8 Hamming bits. That combination fills syndrome positions 1 to 156 and leaves 157 to 255 unused. As a result, the unused-position path can be reached by flipping a few check bits, with no need to corrupt data. With these widths every check-bit index (148 to 156) and every address index (128 to 147) is reachable through `err_pos`. The random cases draw flips uniformly across all 157 stored and address bits, so double errors that mix data, check and address bits all occur.

// File: rtl/secded_pkg.sv
// Shared types and constant functions for the address-folded SECDED codec.
// Assumes a position numbering that starts at 1, with check bits on the
// powers of two.
package secded_pkg;

    // Outcome of one decode.
    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_SINGLE = 2'd1,
        ERR_DOUBLE = 2'd2,
        ERR_ADDR   = 2'd3
    } err_class_e;

    // True when v is a power of two (these positions hold check bits).
    function automatic bit is_pow2(int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

    // Code position of protected bit idx: the idx-th non-power-of-two from 3.
    function automatic int pos_of(int idx);
        int res;
        int cnt;
        res = 0;
        cnt = 0;
        for (int p = 3; p < 1024; p++) begin
            if (!is_pow2(p)) begin
                if (cnt == idx && res == 0) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/secded_hamming_gen.sv
// Hamming bit generator: XOR-folds the code position of every set bit
// of the protected word.
// Assumes K + HAM_W < 2**HAM_W so that every position fits.
module secded_hamming_gen
    import secded_pkg::*;
#(
    parameter int K     = 148,
    parameter int HAM_W = 8
) (
    input  logic [K-1:0]     word,
    output logic [HAM_W-1:0] ham
);

    logic [HAM_W-1:0] contrib [K];

    // Each protected bit contributes its position when it is set.
    for (genvar k = 0; k < K; k++) begin : g_tap
        localparam int P = pos_of(k);
        assign contrib[k] = word[k] ? HAM_W'(P) : '0;
    end

    // Fold all contributions into the Hamming bits.
    always_comb begin
        ham = '0;
        for (int k = 0; k < K; k++) ham = ham ^ contrib[k];
    end

endmodule

// File: rtl/secded_enc.sv
// Encoder: builds the check field over {address, data}.
// Bit HAM_W is the overall even-parity bit.
// Assumes the address is not stored, only folded into the check field.
module secded_enc #(
    parameter int DATA_W = 128,
    parameter int ADDR_W = 20,
    parameter int HAM_W  = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic [ADDR_W-1:0] addr,
    output logic [HAM_W:0]    check
);

    localparam int K = DATA_W + ADDR_W;

    logic [K-1:0]     word;
    logic [HAM_W-1:0] ham;

    assign word = {addr, data};

    secded_hamming_gen #(.K(K), .HAM_W(HAM_W)) u_gen (
        .word (word),
        .ham  (ham)
    );

    // The overall bit makes the parity of the whole codeword even.
    assign check = {^{word, ham}, ham};

endmodule

// File: rtl/secded_classify.sv
// Syndrome classifier: turns the syndrome and the overall parity into an
// error class, a data flip mask and a diagnostic bit index.
// Assumes protected bits 0..DATA_W-1 are data and the rest are address bits.
module secded_classify
    import secded_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int ADDR_W = 20,
    parameter int HAM_W  = 8
) (
    input  logic [HAM_W-1:0]                       syn,
    input  logic                                   par_odd,
    output logic [DATA_W-1:0]                      flip,
    output err_class_e                             cls,
    output logic [$clog2(DATA_W+ADDR_W+HAM_W+1)-1:0] pos
);

    localparam int K     = DATA_W + ADDR_W;
    localparam int POS_W = $clog2(K + HAM_W + 1);

    logic [K-1:0] hit;

    // One comparator per protected bit: does the syndrome name it?
    for (genvar k = 0; k < K; k++) begin : g_hit
        localparam int P = pos_of(k);
        assign hit[k] = (syn == HAM_W'(P));
    end

    // Decide the error class, the correction mask and the reported index.
    always_comb begin
        flip = '0;
        cls  = ERR_NONE;
        pos  = '0;
        if (par_odd) begin
            if (syn == '0) begin
                cls = ERR_SINGLE;
                pos = POS_W'(K + HAM_W);
            end else if ($onehot(syn)) begin
                cls = ERR_SINGLE;
                for (int j = 0; j < HAM_W; j++) begin
                    if (syn[j]) pos = POS_W'(K + j);
                end
            end else if (|hit) begin
                for (int k = 0; k < K; k++) begin
                    if (hit[k]) pos = POS_W'(k);
                end
                if (|hit[K-1:DATA_W]) begin
                    cls = ERR_ADDR;
                end else begin
                    cls  = ERR_SINGLE;
                    flip = hit[DATA_W-1:0];
                end
            end else begin
                cls = ERR_DOUBLE;
            end
        end else if (syn != '0) begin
            cls = ERR_DOUBLE;
        end
    end

endmodule

// File: rtl/secded_addr_codec.sv
// Address-folded SECDED codec top.
// The write side is combinational. The read side decodes combinationally
// and registers its results once.
// Assumes the stored check field came from the encoder with the write address.
module secded_addr_codec
    import secded_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int ADDR_W = 20,
    parameter int HAM_W  = 8
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic [DATA_W-1:0]                        wr_data,
    input  logic [ADDR_W-1:0]                        wr_addr,
    output logic [HAM_W:0]                           wr_check,
    input  logic [DATA_W-1:0]                        rd_data,
    input  logic [HAM_W:0]                           rd_check,
    input  logic [ADDR_W-1:0]                        rd_addr,
    output logic [DATA_W-1:0]                        rd_data_fixed,
    output logic                                     err_single,
    output logic                                     err_double,
    output logic                                     err_addr,
    output logic [$clog2(DATA_W+ADDR_W+HAM_W+1)-1:0] err_pos
);

    localparam int K     = DATA_W + ADDR_W;
    localparam int POS_W = $clog2(K + HAM_W + 1);

    logic [K-1:0]      rd_word;
    logic [HAM_W-1:0]  ham_now;
    logic [HAM_W-1:0]  syn;
    logic              par_odd;
    logic [DATA_W-1:0] flip;
    err_class_e        cls;
    logic [POS_W-1:0]  pos;

    secded_enc #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .HAM_W(HAM_W)) u_enc (
        .data  (wr_data),
        .addr  (wr_addr),
        .check (wr_check)
    );

    assign rd_word = {rd_addr, rd_data};

    secded_hamming_gen #(.K(K), .HAM_W(HAM_W)) u_rgen (
        .word (rd_word),
        .ham  (ham_now)
    );

    // Syndrome and overall parity of the codeword as read.
    assign syn     = ham_now ^ rd_check[HAM_W-1:0];
    assign par_odd = ^{rd_word, rd_check};

    secded_classify #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .HAM_W(HAM_W)) u_cls (
        .syn     (syn),
        .par_odd (par_odd),
        .flip    (flip),
        .cls     (cls),
        .pos     (pos)
    );

    // Register the corrected word and the decode results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_fixed <= '0;
            err_single    <= 1'b0;
            err_double    <= 1'b0;
            err_addr      <= 1'b0;
            err_pos       <= '0;
        end else begin
            rd_data_fixed <= rd_data ^ flip;
            err_single    <= (cls == ERR_SINGLE);
            err_double    <= (cls == ERR_DOUBLE);
            err_addr      <= (cls == ERR_ADDR);
            err_pos       <= pos;
        end
    end

endmodule

// File: rtl/secded_addr_codec_chk.sv
// Property checker for secded_addr_codec, attached by bind.
// Assumes it only observes the ports of the top module.
module secded_addr_codec_chk #(
    parameter int DATA_W = 128,
    parameter int ADDR_W = 20,
    parameter int HAM_W  = 8,
    parameter int POS_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [HAM_W:0]    wr_check,
    input logic [DATA_W-1:0] rd_data,
    input logic [HAM_W:0]    rd_check,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data_fixed,
    input logic              err_single,
    input logic              err_double,
    input logic              err_addr,
    input logic [POS_W-1:0]  err_pos
);

    // A read that matches its write decodes clean and unchanged.
    assert_clean_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data == wr_data && rd_addr == wr_addr && rd_check == wr_check)
        |=> (!err_single && !err_double && !err_addr && rd_data_fixed == $past(rd_data)));

    // A correction changes at most one data bit.
    assert_single_fix_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_single |-> ($countones(rd_data_fixed ^ $past(rd_data)) <= 1));

    // An address error leaves the data untouched.
    assert_addr_keeps_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_addr |-> (rd_data_fixed == $past(rd_data)));

    // An uncorrectable error leaves the data untouched.
    assert_double_keeps_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_double |-> (rd_data_fixed == $past(rd_data)));

    // Reset clears every decode output.
    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (!err_single && !err_double && !err_addr && err_pos == '0 && rd_data_fixed == '0));

    // The three flags never overlap.
    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_single, err_double, err_addr}));

    // The index is zero when no single or address error is flagged.
    assert_pos_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_single || err_addr) |-> (err_pos == '0));

endmodule

bind secded_addr_codec secded_addr_codec_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .HAM_W  (HAM_W),
    .POS_W  ($clog2(DATA_W+ADDR_W+HAM_W+1))
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_data       (wr_data),
    .wr_addr       (wr_addr),
    .wr_check      (wr_check),
    .rd_data       (rd_data),
    .rd_check      (rd_check),
    .rd_addr       (rd_addr),
    .rd_data_fixed (rd_data_fixed),
    .err_single    (err_single),
    .err_double    (err_double),
    .err_addr      (err_addr),
    .err_pos       (err_pos)
);

// File: tb/secded_addr_codec_test.sv
// Self-checking bench for secded_addr_codec: a seeded random mix of
// clean, single, check-bit, address and double corruptions, plus
// directed corner cases.
module secded_addr_codec_test;

    localparam int DW = 128;
    localparam int AW = 20;
    localparam int K  = DW + AW;
    localparam int NB = K + 9;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [DW-1:0]  wr_data = '0;
    logic [AW-1:0]  wr_addr = '0;
    logic [8:0]     wr_check;
    logic [DW-1:0]  rd_data = '0;
    logic [8:0]     rd_check = '0;
    logic [AW-1:0]  rd_addr = '0;
    logic [DW-1:0]  rd_data_fixed;
    logic           err_single;
    logic           err_double;
    logic           err_addr;
    logic [7:0]     err_pos;

    int checks = 0;
    int errors = 0;
    int pos_tab [K];

    secded_addr_codec uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_data       (wr_data),
        .wr_addr       (wr_addr),
        .wr_check      (wr_check),
        .rd_data       (rd_data),
        .rd_check      (rd_check),
        .rd_addr       (rd_addr),
        .rd_data_fixed (rd_data_fixed),
        .err_single    (err_single),
        .err_double    (err_double),
        .err_addr      (err_addr),
        .err_pos       (err_pos)
    );

    // 125 MHz clock.
    always #4 clk = ~clk;

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // One comparison: counts it and reports any mismatch.
    task automatic cmp(string req, logic [159:0] act, logic [159:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference check field, built from the position rule of R1.
    function automatic logic [8:0] ref_check(logic [DW-1:0] d, logic [AW-1:0] a);
        logic [K-1:0] w;
        logic [7:0]   h;
        w = {a, d};
        h = '0;
        for (int k = 0; k < K; k++) if (w[k]) h = h ^ pos_tab[k][7:0];
        return {(^w) ^ (^h), h};
    endfunction

    // Drive one read at a falling edge; sample at the next falling edge.
    task automatic read(logic [DW-1:0] d, logic [8:0] c, logic [AW-1:0] a);
        @(negedge clk);
        rd_data  = d;
        rd_check = c;
        rd_addr  = a;
        @(negedge clk);
    endtask

    // Compare all decode outputs with expected values.
    task automatic expect_out(string req, logic [DW-1:0] d, logic s, logic dd,
                              logic ae, logic [7:0] p);
        cmp(req, 160'(rd_data_fixed), 160'(d));
        cmp(req, 160'({err_single, err_double, err_addr}), 160'({s, dd, ae}));
        cmp(req, 160'(err_pos), 160'(p));
    endtask

    initial begin
        logic [DW-1:0] d, rd;
        logic [AW-1:0] a, ra;
        logic [8:0]    c, rc;
        int            cnt;
        int            p;

        // Build the position table: skip powers of two, starting at 3.
        cnt = 0;
        p = 3;
        while (cnt < K) begin
            if ((p & (p - 1)) != 0) begin
                pos_tab[cnt] = p;
                cnt++;
            end
            p++;
        end
        void'($urandom(32'd20240611));

        // R8: reset state.
        rd_data = '1;
        rd_check = 9'h1ff;
        repeat (3) @(negedge clk);
        expect_out("R8 reset", '0, 1'b0, 1'b0, 1'b0, 8'd0);
        rst_n = 1'b1;

        // R1: directed encoder values.
        wr_data = '0;
        wr_addr = '0;
        #1 cmp("R1 zero word", 160'(wr_check), 160'(9'h000));
        wr_data = 128'd1;
        #1 cmp("R1 data bit 0", 160'(wr_check), 160'(9'h103));

        // Random mix across every corruption class.
        for (int i = 0; i < 60; i++) begin
            int kind;
            int b1, b2;
            d  = {$urandom, $urandom, $urandom, $urandom};
            a  = AW'($urandom);
            c  = ref_check(d, a);
            @(negedge clk);
            wr_data = d;
            wr_addr = a;
            #1 cmp("R1 encoder", 160'(wr_check), 160'(c));
            rd = d;
            ra = a;
            rc = c;
            kind = i % 5;
            case (kind)
                0: begin
                    read(rd, rc, ra);
                    expect_out("R2 clean", d, 1'b0, 1'b0, 1'b0, 8'd0);
                end
                1: begin
                    b1 = $urandom_range(DW - 1);
                    rd[b1] = ~rd[b1];
                    read(rd, rc, ra);
                    expect_out("R3 data flip", d, 1'b1, 1'b0, 1'b0, 8'(b1));
                end
                2: begin
                    b1 = $urandom_range(8);
                    rc[b1] = ~rc[b1];
                    read(rd, rc, ra);
                    expect_out("R4 check flip", d, 1'b1, 1'b0, 1'b0, 8'(K + b1));
                end
                3: begin
                    b1 = $urandom_range(AW - 1);
                    ra[b1] = ~ra[b1];
                    read(rd, rc, ra);
                    expect_out("R5 address", d, 1'b0, 1'b0, 1'b1, 8'(DW + b1));
                end
                default: begin
                    b1 = $urandom_range(NB - 1);
                    b2 = $urandom_range(NB - 2);
                    if (b2 >= b1) b2++;
                    for (int t = 0; t < 2; t++) begin
                        int b;
                        b = (t == 0) ? b1 : b2;
                        if (b < DW)      rd[b] = ~rd[b];
                        else if (b < K)  ra[b - DW] = ~ra[b - DW];
                        else             rc[b - K] = ~rc[b - K];
                    end
                    read(rd, rc, ra);
                    expect_out("R6 double", rd, 1'b0, 1'b1, 1'b0, 8'd0);
                end
            endcase
        end

        // R3/R5 boundaries: last data bit, first and last address bits.
        d = '0;
        a = '0;
        c = ref_check(d, a);
        rd = d;
        rd[DW-1] = 1'b1;
        read(rd, c, a);
        expect_out("R3 top data bit", d, 1'b1, 1'b0, 1'b0, 8'd127);
        read(d, c, 20'h00001);
        expect_out("R5 address bit 0", d, 1'b0, 1'b0, 1'b1, 8'd128);
        read(d, c, 20'h80000);
        expect_out("R5 address bit 19", d, 1'b0, 1'b0, 1'b1, 8'd147);

        // R7: check bits 3, 6, 7 flipped give syndrome 200 with odd parity.
        d = {$urandom, $urandom, $urandom, $urandom};
        a = AW'($urandom);
        c = ref_check(d, a);
        read(d, c ^ 9'b0_1100_1000, a);
        expect_out("R7 unused position", d, 1'b0, 1'b1, 1'b0, 8'd0);

        // R8: outputs hold until the next rising edge after new inputs.
        rd = d;
        rd[5] = ~rd[5];
        read(rd, c, a);
        rd_data  = d;
        rd_addr  = a ^ 20'h00004;
        #1 expect_out("R8 hold", d, 1'b1, 1'b0, 1'b0, 8'd5);
        @(negedge clk);
        expect_out("R8 update", d, 1'b0, 1'b0, 1'b1, 8'd130);

        // R8: reset taken mid-run clears the outputs.
        rst_n = 1'b0;
        @(negedge clk);
        expect_out("R8 reset again", '0, 1'b0, 1'b0, 1'b0, 8'd0);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule